// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block gathers wake requests from six sources into a small bank of runtime registers and drives an active-low power-management event line toward the system. The sources are a hardware-monitor alarm, two ring-indicator lines, the keyboard, the mouse and an infrared receiver. The first five arrive as synchronous event pulses. The infrared receive line is asynchronous: it passes through a synchronizer, and any change of level counts as a wake event.

Software uses a byte-wide register port (offset, write strobe, read strobe, write data and registered read data) to reach three registers:

- **Global status.** A single sticky bit that records that some wake occurred. Writing 1 clears it.
- **Global enable.** A single read/write bit that gates the event line.
- **Per-source wake status.** A byte in which every source has its own sticky bit. Writing 1 to a bit clears it.

Status bits latch whatever the enable holds, so a sleeping system can find out afterwards what woke it.

The block has two reset domains. The standby-power reset clears all state. The system reset stands for the main-power, soft and bus resets. It clears only the read-data register and leaves every wake bit, the enable and the event line as they were.

Top module: `wake_evt_ctrl`

## Requirements
- R1: While `stby_rst_n` is low, all three registers are 0x00 and `pme_n` is 1. After release, each register reads 0x00.
- R2: Pulsing `sys_rst_n` low leaves global status, global enable, wake status and `pme_n` unchanged.
- R3: Wake status bit positions are fixed: bit 0 hardware monitor, bit 1 ring indicator 2, bit 2 ring indicator 1, bit 3 keyboard, bit 4 mouse, bit 6 infrared. Bits 5 and 7 always read 0, and writes to them have no effect.
- R4: A wake event sets its wake status bit on the next clock edge, regardless of the global enable.
- R5: Any wake event sets global status bit 0 (offset 0x00) on the next clock edge, regardless of the global enable. Bits 7:1 of global status read 0.
- R6: Writing the wake status register (offset 0x04) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Writing 1 to global status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: The global enable bit 0 (offset 0x02) is read/write and defaults to 0. Bits 7:1 read 0.
- R9: `pme_n` is registered. It goes low one clock edge after global enable is 1 while global status or any wake status bit is set. It goes high one edge after that condition stops holding, and stays high whenever enable is 0.
- R10: If a wake event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: Either transition of `ir_rx` sets wake bit 6 within three clock edges, after a two-stage synchronizer. A steady `ir_rx` sets nothing.
- R12: `reg_rdata` is loaded on the edge where `reg_rd` is high and holds its value otherwise. An undecoded offset reads 0x00, and `reg_rdata` clears under either reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-power reset, async, active low; clears all state |
| sys_rst_n | input | 1 | Main-power/soft/bus reset, async, active low; clears only read data |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| hwm_evt | input | 1 | Hardware-monitor wake pulse |
| ri2_evt | input | 1 | Ring indicator 2 wake pulse |
| ri1_evt | input | 1 | Ring indicator 1 wake pulse |
| kbd_evt | input | 1 | Keyboard wake pulse |
| mouse_evt | input | 1 | Mouse wake pulse |
| ir_rx | input | 1 | Asynchronous infrared receive line |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The embedded assertions check these properties on every cycle:

- A set bit wins over a clear of the same bit in the same cycle.
- A written 1 clears its bit, and a bit that is neither set nor cleared holds its value.
- Any event sets global status.
- An enable write lands as written.
- `pme_n` follows enable and pending status one edge later.
- Read data holds between reads.

Only the bench scenarios can show the rest:

- The mapping from each source to its bit position.
- That reserved bits stay zero.
- That the system reset leaves wake state in place while the standby reset clears it.
- That both infrared transitions are caught after the synchronizer, and that a steady infrared level sets nothing.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int REG_W     = 8;
   localparam int BIT_HWM   = 0;
   localparam int BIT_RI2   = 1;
   localparam int BIT_RI1   = 2;
   localparam int BIT_KBD   = 3;
   localparam int BIT_MOUSE = 4;
   localparam int BIT_IR    = 6;
   // implemented wake status bits; 5 and 7 are reserved
   localparam logic [REG_W-1:0] WAKE_IMPL = 8'b0101_1111;

   typedef enum logic [1:0] {
      EDGE_BOTH = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_mode_e;
endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
   parameter int unsigned         STAGES = 2,
   parameter wake_pkg::edge_mode_e MODE  = wake_pkg::EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic edge_o
);
   // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
   logic [STAGES:0] chain_q;
   logic            cur_lvl;
   logic            prev_lvl;

   if (STAGES < 2) begin : g_bad_stages
      $error("wake_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], d_i};
   end

   assign cur_lvl  = chain_q[STAGES-1];
   assign prev_lvl = chain_q[STAGES];

   if (MODE == wake_pkg::EDGE_RISE) begin : g_rise
      assign edge_o = cur_lvl & ~prev_lvl;
   end else if (MODE == wake_pkg::EDGE_FALL) begin : g_fall
      assign edge_o = ~cur_lvl & prev_lvl;
   end else begin : g_both
      assign edge_o = cur_lvl ^ prev_lvl;
   end
endmodule

// File: rtl/wake_w1c_bank.sv
module wake_w1c_bank #(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] IMPL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("wake_w1c_bank: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (IMPL[i]) begin : g_impl
         logic bit_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         bit_q <= 1'b0;
            else if (set_i[i])  bit_q <= 1'b1;  // set beats clear
            else if (clr_i[i])  bit_q <= 1'b0;
         end
         assign q_o[i] = bit_q;

         assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
         assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
         assert_w1c_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> (q_o[i] == $past(q_o[i])));
      end else begin : g_rsvd
         logic unused_rsvd;
         assign unused_rsvd = set_i[i] ^ clr_i[i];
         assign q_o[i]      = 1'b0;
      end
   end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl #(
   parameter int unsigned          ADDR_W      = 3,
   parameter logic [ADDR_W-1:0]    STS_OFS     = 'h0,
   parameter logic [ADDR_W-1:0]    EN_OFS      = 'h2,
   parameter logic [ADDR_W-1:0]    WAKE_OFS    = 'h4,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter wake_pkg::edge_mode_e IR_EDGE     = wake_pkg::EDGE_BOTH
) (
   input  logic              clk,
   input  logic              stby_rst_n,
   input  logic              sys_rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              hwm_evt,
   input  logic              ri2_evt,
   input  logic              ri1_evt,
   input  logic              kbd_evt,
   input  logic              mouse_evt,
   input  logic              ir_rx,
   output logic              pme_n
);
   import wake_pkg::*;

   localparam logic [REG_W-1:0] ZERO_PAD = '0;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("wake_evt_ctrl: ADDR_W must be at least 1");
   end
   if (STS_OFS == EN_OFS || STS_OFS == WAKE_OFS || EN_OFS == WAKE_OFS) begin : g_bad_ofs
      $error("wake_evt_ctrl: register offsets must be distinct");
   end

   logic             ir_edge;
   logic [REG_W-1:0] wake_set;
   logic [REG_W-1:0] wake_clr;
   logic [REG_W-1:0] wake_q;
   logic             any_evt;
   logic             sts_q;
   logic             en_q;
   logic             wr_sts, wr_en, wr_wake;
   logic             pme_n_q;
   logic             bus_rst_n;
   logic [REG_W-1:0] rd_mux;
   logic [REG_W-1:0] rdata_q;

   // infrared line: synchronize, then detect transitions
   wake_edge_sync #(
      .STAGES (SYNC_STAGES),
      .MODE   (IR_EDGE)
   ) u_ir_sync (
      .clk    (clk),
      .rst_n  (stby_rst_n),
      .d_i    (ir_rx),
      .edge_o (ir_edge)
   );

   always_comb begin
      wake_set            = '0;
      wake_set[BIT_HWM]   = hwm_evt;
      wake_set[BIT_RI2]   = ri2_evt;
      wake_set[BIT_RI1]   = ri1_evt;
      wake_set[BIT_KBD]   = kbd_evt;
      wake_set[BIT_MOUSE] = mouse_evt;
      wake_set[BIT_IR]    = ir_edge;
   end
   assign any_evt = |wake_set;

   // register decode
   assign wr_sts  = reg_wr && (reg_addr == STS_OFS);
   assign wr_en   = reg_wr && (reg_addr == EN_OFS);
   assign wr_wake = reg_wr && (reg_addr == WAKE_OFS);
   assign wake_clr = wr_wake ? reg_wdata : '0;

   wake_w1c_bank #(
      .WIDTH (REG_W),
      .IMPL  (WAKE_IMPL)
   ) u_wake_bank (
      .clk   (clk),
      .rst_n (stby_rst_n),
      .set_i (wake_set),
      .clr_i (wake_clr),
      .q_o   (wake_q)
   );

   wake_w1c_bank #(
      .WIDTH (1),
      .IMPL  (1'b1)
   ) u_sts_bank (
      .clk   (clk),
      .rst_n (stby_rst_n),
      .set_i (any_evt),
      .clr_i (wr_sts & reg_wdata[0]),
      .q_o   (sts_q)
   );

   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n) en_q <= 1'b0;
      else if (wr_en)  en_q <= reg_wdata[0];
   end

   // event output, standby domain only
   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n) pme_n_q <= 1'b1;
      else             pme_n_q <= !(en_q && (sts_q || (|wake_q)));
   end
   assign pme_n = pme_n_q;

   // read path, cleared by either reset
   assign bus_rst_n = stby_rst_n & sys_rst_n;

   always_comb begin
      rd_mux = '0;
      if (reg_addr == STS_OFS)       rd_mux = {ZERO_PAD[REG_W-1:1], sts_q};
      else if (reg_addr == EN_OFS)   rd_mux = {ZERO_PAD[REG_W-1:1], en_q};
      else if (reg_addr == WAKE_OFS) rd_mux = wake_q;
   end

   always_ff @(posedge clk or negedge bus_rst_n) begin
      if (!bus_rst_n)  rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end
   assign reg_rdata = rdata_q;

   assert_sts_on_event_R5: assert property (@(posedge clk) disable iff (!stby_rst_n)
      any_evt |=> sts_q);
   assert_en_write_R8: assert property (@(posedge clk) disable iff (!stby_rst_n)
      wr_en |=> (en_q == $past(reg_wdata[0])));
   assert_pme_assert_R9: assert property (@(posedge clk) disable iff (!stby_rst_n)
      (en_q && (sts_q || (|wake_q))) |=> !pme_n);
   assert_pme_blocked_R9: assert property (@(posedge clk) disable iff (!stby_rst_n)
      !en_q |=> pme_n);
   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!bus_rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/wake_evt_ctrl_test.sv
module wake_evt_ctrl_test;
   localparam logic [2:0] A_STS  = 3'h0;
   localparam logic [2:0] A_EN   = 3'h2;
   localparam logic [2:0] A_WAKE = 3'h4;
   localparam logic [2:0] A_NONE = 3'h6;

   logic       clk = 1'b0;
   logic       stby_rst_n = 1'b0;
   logic       sys_rst_n  = 1'b0;
   logic [2:0] reg_addr   = '0;
   logic       reg_wr     = 1'b0;
   logic       reg_rd     = 1'b0;
   logic [7:0] reg_wdata  = '0;
   logic [7:0] reg_rdata;
   logic       hwm_evt = 1'b0, ri2_evt = 1'b0, ri1_evt = 1'b0;
   logic       kbd_evt = 1'b0, mouse_evt = 1'b0, ir_rx = 1'b0;
   logic       pme_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   wake_evt_ctrl uut (
      .clk(clk), .stby_rst_n(stby_rst_n), .sys_rst_n(sys_rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hwm_evt(hwm_evt), .ri2_evt(ri2_evt), .ri1_evt(ri1_evt),
      .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .ir_rx(ir_rx),
      .pme_n(pme_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic drive_src(input logic [7:0] m);
      hwm_evt = m[0]; ri2_evt = m[1]; ri1_evt = m[2];
      kbd_evt = m[3]; mouse_evt = m[4];
   endtask

   // one-cycle pulse on the sources selected by wake-bit position
   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      drive_src(m);
      @(negedge clk);
      drive_src(8'h00);
   endtask

   task automatic clear_all();
      wr(A_WAKE, 8'hFF);
      wr(A_STS, 8'hFF);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      check("R1 pme_n in standby reset", {7'd0, pme_n}, 8'h01);
      @(negedge clk);
      stby_rst_n = 1'b1; sys_rst_n = 1'b1;
      rd(A_STS, d);  check("R1 status after reset", d, 8'h00);
      rd(A_EN, d);   check("R1 enable after reset", d, 8'h00);
      rd(A_WAKE, d); check("R1 wake after reset", d, 8'h00);
      rd(A_NONE, d); check("R12 undecoded offset", d, 8'h00);
   endtask

   task automatic t_source_map();
      logic [7:0] d;
      for (int p = 0; p < 5; p++) begin
         pulse(8'h01 << p);
         rd(A_WAKE, d); check("R3 R4 source bit position", d, 8'h01 << p);
         rd(A_STS, d);  check("R5 status set with enable 0", d, 8'h01);
         check("R9 pme_n blocked while enable 0", {7'd0, pme_n}, 8'h01);
         clear_all();
      end
   endtask

   task automatic t_clear_rules();
      logic [7:0] d;
      pulse(8'h1F);
      wr(A_WAKE, 8'h00); rd(A_WAKE, d); check("R6 write 0 no effect", d, 8'h1F);
      wr(A_WAKE, 8'h0A); rd(A_WAKE, d); check("R6 selective clear", d, 8'h15);
      wr(A_WAKE, 8'hA0); rd(A_WAKE, d); check("R3 reserved bit write", d, 8'h15);
      wr(A_STS, 8'h00);  rd(A_STS, d);  check("R7 status write 0", d, 8'h01);
      wr(A_STS, 8'h01);  rd(A_STS, d);  check("R7 status write 1", d, 8'h00);
      wr(A_WAKE, 8'hFF); rd(A_WAKE, d); check("R6 clear all", d, 8'h00);
   endtask

   task automatic t_enable_output();
      logic [7:0] d;
      wr(A_EN, 8'hFF); rd(A_EN, d); check("R8 enable readback", d, 8'h01);
      check("R9 idle pme_n", {7'd0, pme_n}, 8'h01);
      pulse(8'h08);
      check("R9 pme_n one edge after bit set", {7'd0, pme_n}, 8'h01);
      @(negedge clk);
      check("R9 pme_n asserted", {7'd0, pme_n}, 8'h00);
      wr(A_WAKE, 8'hFF);
      @(negedge clk);
      check("R9 status still pending", {7'd0, pme_n}, 8'h00);
      wr(A_STS, 8'h01);
      check("R9 pme_n one edge after clear", {7'd0, pme_n}, 8'h00);
      @(negedge clk);
      check("R9 pme_n released", {7'd0, pme_n}, 8'h01);
      wr(A_EN, 8'h00);
      pulse(8'h10);
      repeat (2) @(negedge clk);
      check("R9 R4 disabled pme_n", {7'd0, pme_n}, 8'h01);
      rd(A_WAKE, d); check("R4 latched while disabled", d, 8'h10);
      clear_all();
   endtask

   task automatic t_collision();
      logic [7:0] d;
      @(negedge clk);
      kbd_evt = 1'b1; reg_addr = A_WAKE; reg_wdata = 8'h08; reg_wr = 1'b1;
      @(negedge clk);
      kbd_evt = 1'b0; reg_wr = 1'b0;
      rd(A_WAKE, d); check("R10 wake set beats clear", d, 8'h08);
      wr(A_STS, 8'h01);
      @(negedge clk);
      mouse_evt = 1'b1; reg_addr = A_STS; reg_wdata = 8'h01; reg_wr = 1'b1;
      @(negedge clk);
      mouse_evt = 1'b0; reg_wr = 1'b0;
      rd(A_STS, d); check("R10 status set beats clear", d, 8'h01);
      clear_all();
   endtask

   task automatic t_infrared();
      logic [7:0] d;
      @(negedge clk); ir_rx = 1'b1;
      repeat (3) @(negedge clk);
      rd(A_WAKE, d); check("R11 rising edge", d, 8'h40);
      clear_all();
      repeat (10) @(negedge clk);
      rd(A_WAKE, d); check("R11 steady level", d, 8'h00);
      @(negedge clk); ir_rx = 1'b0;
      repeat (3) @(negedge clk);
      rd(A_WAKE, d); check("R11 falling edge", d, 8'h40);
      rd(A_STS, d);  check("R5 status from infrared", d, 8'h01);
      clear_all();
   endtask

   task automatic t_sys_reset();
      logic [7:0] d;
      wr(A_EN, 8'h01);
      pulse(8'h02);
      rd(A_WAKE, d); check("R4 ring 2 before sys reset", d, 8'h02);
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk);
      check("R12 rdata cleared by sys reset", reg_rdata, 8'h00);
      check("R2 pme_n kept in sys reset", {7'd0, pme_n}, 8'h00);
      sys_rst_n = 1'b1;
      rd(A_WAKE, d); check("R2 wake kept", d, 8'h02);
      rd(A_EN, d);   check("R2 enable kept", d, 8'h01);
      rd(A_STS, d);  check("R2 status kept", d, 8'h01);
   endtask

   task automatic t_standby();
      logic [7:0] d;
      @(negedge clk); stby_rst_n = 1'b0;
      @(negedge clk);
      check("R1 pme_n in standby reset", {7'd0, pme_n}, 8'h01);
      stby_rst_n = 1'b1;
      rd(A_WAKE, d); check("R1 wake cleared", d, 8'h00);
      rd(A_EN, d);   check("R1 enable cleared", d, 8'h00);
      rd(A_STS, d);  check("R1 status cleared", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_source_map();
      t_clear_rules();
      t_enable_output();
      t_collision();
      t_infrared();
      t_sys_reset();
      t_standby();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule